// File: doc/BRIEF.md
# Debug Register Scan Chain

This block is a 38-bit data-register chain that sits behind a test access port and lets an external debugger read and write a small bank of on-chip debug registers. It is clocked by the test clock. The port controller supplies the capture, shift and update strobes and a chain-select line. A frame shifts in least significant bit first. Its bits 31:0 are data, bits 36:32 are a register address, and bit 37 is a direction flag: 1 writes and 0 reads.

A read takes two scans. At Update-DR, a read frame latches its address. The next Capture-DR loads the selected register into bits 31:0 of the chain, and the scan that follows shifts it out. A write frame stores its data at Update-DR, cut to the width of the target register. The bank holds debug control, debug status, vector catch, comms control, comms data and two watch units, each with six value and mask registers. Capturing the comms data register consumes the pending word. Capturing comms control has no side effect, so comms control is the safe address for the closing scan of a read sequence.

Top module: `dbg_scan_regs`

## Requirements
- R1: While selected with Shift-DR high, each rising test clock edge moves the chain one bit toward bit 0. TDI enters bit 37 and TDO shows bit 0.
- R2: An update of a read frame (bit 37 = 0) latches bits 36:32 as the read address. The next selected Capture-DR loads that register's value into bits 31:0 and zeroes bits 37:32.
- R3: An update of a write frame (bit 37 = 1) stores bits 31:0 into the addressed register, keeping only the implemented width:
  - debug control: 6 bits
  - debug status: 5 bits
  - vector catch: 8 bits
  - comms control: 6 bits
  - comms data: 32 bits
  - watch address and data value/mask registers: 32 bits
  - watch control value: 9 bits
  - watch control mask: 8 bits
  
  Unimplemented upper bits read back as zero.
- R4: The address map is as follows:
  - debug control: 0
  - debug status: 1
  - vector catch: 2
  - comms control: 4
  - comms data: 5
  - watch unit 0: 8 to 13
  - watch unit 1: 16 to 21
  
  Within a watch unit, the six offsets from 0 to 5 are address value, address mask, data value, data mask, control value and control mask.
- R5: Any other 5-bit address captures zero, and a write to it changes no register.
- R6: Comms control reads bits 31:28 as the fixed version parameter (default 6) and bit 0 as a word-pending flag. Bits 5:1 are written normally. A write to bit 0 has no effect.
- R7: A write to comms data sets the pending flag. A capture with comms data as the read target clears it. A capture of comms control leaves it unchanged.
- R8: While deselected, the chain does not capture, shift or update, TDO is 0, and neither strobe is raised.
- R9: Reset (active low, asynchronous) clears every register, the read address and the chain, so the first capture after reset returns debug control, which is 0.
- R10: The write strobe is high during a selected update of a write frame, with the frame's address and data on the bank pins. The read strobe is high during a selected capture, with the read address on the bank address pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chain select |
| capture_dr | input | 1 | Capture-DR state strobe |
| shift_dr | input | 1 | Shift-DR state strobe |
| update_dr | input | 1 | Update-DR state strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| bank_addr | output | 5 | Register address being written or read |
| bank_wdata | output | 32 | Write data from the frame |
| bank_we | output | 1 | Write strobe |
| bank_re | output | 1 | Read (capture) strobe |

## Verification
The assertions check on every cycle that the strobes only occur in selected update or capture states, that TDO stays quiet while the chain is deselected, and that the bank address holds between updates. Only the bench's scans can show the two-scan read pipeline, the width truncation and map of each register, the consumption of the comms word and the pending flag's behaviour, and the effect of ignored writes. The bench compares every captured frame against a register model of its own.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
  localparam int FRAME_W = 38;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int NWATCH  = 2;
  localparam int WREGS   = 6;

  localparam logic [ADDR_W-1:0] A_DCTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_DSTAT = 5'd1;
  localparam logic [ADDR_W-1:0] A_VCAT  = 5'd2;
  localparam logic [ADDR_W-1:0] A_CCTRL = 5'd4;
  localparam logic [ADDR_W-1:0] A_CDATA = 5'd5;

  localparam int DCTRL_W = 6;
  localparam int DSTAT_W = 5;
  localparam int VCAT_W  = 8;
  localparam int CCTRL_W = 6;

  function automatic logic [DATA_W-1:0] watch_mask(input int idx);
    case (idx)
      4:       watch_mask = 32'h0000_01FF;
      5:       watch_mask = 32'h0000_00FF;
      default: watch_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dbg_shift_frame.sv
module dbg_shift_frame
  import dbg_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              shf,
  input  logic              tdi,
  input  logic [DATA_W-1:0] cap_data,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame <= '0;
    else if (cap)
      frame <= {{(FRAME_W-DATA_W){1'b0}}, cap_data};
    else if (shf)
      frame <= {tdi, frame[FRAME_W-1:1]};
  end
endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_scan_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'h6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DCTRL_W-1:0] dctrl_q;
  logic [DSTAT_W-1:0] dstat_q;
  logic [VCAT_W-1:0]  vcat_q;
  logic [CCTRL_W-1:1] cctrl_q;
  logic               pend_q;
  logic [DATA_W-1:0]  cdata_q;
  logic [DATA_W-1:0]  watch_q [NWATCH][WREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dctrl_q <= '0;
      dstat_q <= '0;
      vcat_q  <= '0;
      cctrl_q <= '0;
      cdata_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (we) begin
        case (waddr)
          A_DCTRL: dctrl_q <= wdata[DCTRL_W-1:0];
          A_DSTAT: dstat_q <= wdata[DSTAT_W-1:0];
          A_VCAT:  vcat_q  <= wdata[VCAT_W-1:0];
          A_CCTRL: cctrl_q <= wdata[CCTRL_W-1:1];
          A_CDATA: cdata_q <= wdata;
          default: ;
        endcase
      end
      if (we && waddr == A_CDATA)
        pend_q <= 1'b1;
      else if (re && raddr == A_CDATA)
        pend_q <= 1'b0;
    end
  end

  for (genvar u = 0; u < NWATCH; u++) begin : g_unit
    localparam logic [1:0] BASE = 2'(u + 1);
    for (genvar r = 0; r < WREGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          watch_q[u][r] <= '0;
        else if (we && waddr[4:3] == BASE && waddr[2:0] == 3'(r))
          watch_q[u][r] <= wdata & watch_mask(r);
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      A_DCTRL: rdata = DATA_W'(dctrl_q);
      A_DSTAT: rdata = DATA_W'(dstat_q);
      A_VCAT:  rdata = DATA_W'(vcat_q);
      A_CCTRL: rdata = {VERSION, 22'b0, cctrl_q, pend_q};
      A_CDATA: rdata = cdata_q;
      default: begin
        for (int u = 0; u < NWATCH; u++)
          if (raddr[4:3] == 2'(u + 1) && raddr[2:0] < 3'(WREGS))
            rdata = watch_q[u][raddr[2:0]];
      end
    endcase
  end
endmodule

// File: rtl/dbg_scan_regs.sv
module dbg_scan_regs
  import dbg_scan_pkg::*;
#(
  parameter logic [3:0] VERSION = 4'h6
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bank_addr,
  output logic [DATA_W-1:0] bank_wdata,
  output logic              bank_we,
  output logic              bank_re
);
  logic               cap, shf, upd;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  rd_addr_q;
  logic [DATA_W-1:0]  rdata;
  logic               fr_wr;
  logic [ADDR_W-1:0]  fr_addr;

  assign cap     = sel & capture_dr;
  assign shf     = sel & shift_dr;
  assign upd     = sel & update_dr;
  assign fr_wr   = frame[FRAME_W-1];
  assign fr_addr = frame[DATA_W +: ADDR_W];

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)
      rd_addr_q <= '0;
    else if (upd && !fr_wr)
      rd_addr_q <= fr_addr;
  end

  dbg_shift_frame u_shift (
    .clk      (tck),
    .rst_n    (rst_n),
    .cap      (cap),
    .shf      (shf),
    .tdi      (tdi),
    .cap_data (rdata),
    .frame    (frame)
  );

  dbg_reg_bank #(.VERSION(VERSION)) u_bank (
    .clk   (tck),
    .rst_n (rst_n),
    .we    (bank_we),
    .waddr (fr_addr),
    .wdata (frame[DATA_W-1:0]),
    .re    (cap),
    .raddr (rd_addr_q),
    .rdata (rdata)
  );

  assign bank_we    = upd & fr_wr;
  assign bank_re    = cap;
  assign bank_addr  = bank_we ? fr_addr : rd_addr_q;
  assign bank_wdata = frame[DATA_W-1:0];
  assign tdo        = sel ? frame[0] : 1'b0;
endmodule

module dbg_scan_regs_chk (
  input logic       tck,
  input logic       rst_n,
  input logic       sel,
  input logic       capture_dr,
  input logic       update_dr,
  input logic       tdo,
  input logic [4:0] bank_addr,
  input logic       bank_we,
  input logic       bank_re
);
  a_r8_tdo_quiet: assert property (@(posedge tck) disable iff (!rst_n)
    !sel |-> tdo == 1'b0);
  a_r10_we_in_update: assert property (@(posedge tck) disable iff (!rst_n)
    bank_we |-> (sel && update_dr));
  a_r10_re_in_capture: assert property (@(posedge tck) disable iff (!rst_n)
    bank_re |-> (sel && capture_dr));
  a_r2_addr_holds: assert property (@(posedge tck) disable iff (!rst_n)
    (!bank_we && !(sel && update_dr)) |=> (bank_we || $stable(bank_addr)));
endmodule

bind dbg_scan_regs dbg_scan_regs_chk u_chk (
  .tck(tck), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
  .update_dr(update_dr), .tdo(tdo), .bank_addr(bank_addr),
  .bank_we(bank_we), .bank_re(bank_re)
);

// File: tb/dbg_scan_regs_tb_top.sv
module dbg_scan_regs_tb_top;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic tdo, bank_we, bank_re;
  logic [4:0] bank_addr;
  logic [31:0] bank_wdata;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m [32];
  logic m_pend;
  logic [4:0] m_rd;
  localparam logic [3:0] VER = 4'h6;

  always #5 tck = ~tck;

  dbg_scan_regs dut_i (
    .tck(tck), .rst_n(rst_n), .sel(sel), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .bank_we(bank_we), .bank_re(bank_re)
  );

  function automatic logic [31:0] wmask(input logic [4:0] a);
    case (a)
      5'd0: wmask = 32'h3F;
      5'd1: wmask = 32'h1F;
      5'd2: wmask = 32'hFF;
      5'd4: wmask = 32'h3E;
      5'd5: wmask = 32'hFFFF_FFFF;
      default:
        if ((a[4:3] == 2'd1 || a[4:3] == 2'd2) && a[2:0] < 3'd6)
          wmask = (a[2:0] == 3'd4) ? 32'h1FF :
                  (a[2:0] == 3'd5) ? 32'hFF : 32'hFFFF_FFFF;
        else
          wmask = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mread(input logic [4:0] a);
    if (a == 5'd4) mread = {VER, 22'b0, m[4][5:1], m_pend};
    else           mread = m[a];
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic scan(input string tag, input logic s, input logic wr,
                      input logic [4:0] a, input logic [31:0] d);
    logic [37:0] f, got, exp;
    f = {wr, a, d};
    exp = s ? {6'b0, mread(m_rd)} : 38'b0;
    @(negedge tck);
    sel = s; capture_dr = 1'b1;
    #1 check({tag, " R10 re"}, {63'b0, bank_re}, {63'b0, s});
    if (s) check({tag, " R10 raddr"}, {59'b0, bank_addr}, {59'b0, m_rd});
    if (s && m_rd == 5'd5) m_pend = 1'b0;
    @(negedge tck);
    capture_dr = 1'b0; shift_dr = 1'b1;
    for (int i = 0; i < 38; i++) begin
      got[i] = tdo;
      tdi = f[i];
      @(negedge tck);
    end
    shift_dr = 1'b0; update_dr = 1'b1;
    #1 check({tag, " R10 we"}, {63'b0, bank_we}, {63'b0, s & wr});
    if (s && wr) begin
      check({tag, " R10 waddr"}, {59'b0, bank_addr}, {59'b0, a});
      check({tag, " R10 wdata"}, {32'b0, bank_wdata}, {32'b0, d});
    end
    check({tag, " R1 R2 frame"}, {26'b0, got}, {26'b0, exp});
    if (s) begin
      if (wr) begin
        if (a == 5'd5) m_pend = 1'b1;
        m[a] = d & wmask(a);
      end else m_rd = a;
    end
    @(negedge tck);
    update_dr = 1'b0; sel = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a);
    scan(tag, 1'b1, 1'b0, a, 32'h0);
    scan(tag, 1'b1, 1'b0, 5'd4, 32'h0);
  endtask

  logic done = 1'b0;

  initial begin
    for (int i = 0; i < 32; i++) m[i] = '0;
    m_pend = 1'b0; m_rd = '0;
    repeat (3) @(negedge tck);
    #1 check("R9 tdo reset", {63'b0, tdo}, 64'b0);
    check("R9 strobes reset", {62'b0, bank_we, bank_re}, 64'b0);
    rst_n = 1'b1;
    rd("R9 first read", 5'd0);
    for (int a = 0; a < 32; a++) scan("R3 R4 R5 fill", 1'b1, 1'b1, 5'(a), 32'hFFFF_FFFF);
    for (int a = 0; a < 32; a++) rd("R3 R4 R5 readback", 5'(a));
    for (int a = 0; a < 32; a++) scan("R4 distinct", 1'b1, 1'b1, 5'(a), 32'h0100_0000 * a + 32'h0001_0203 * a);
    for (int a = 0; a < 32; a++) rd("R4 distinct read", 5'(a));
    scan("R6 write ctrl", 1'b1, 1'b1, 5'd4, 32'hFFFF_FFC1);
    rd("R6 version", 5'd4);
    scan("R7 send word", 1'b1, 1'b1, 5'd5, 32'hCAFE_F00D);
    rd("R7 pend set", 5'd4);
    rd("R7 ctrl no effect", 5'd4);
    rd("R7 consume", 5'd5);
    rd("R7 pend clear", 5'd4);
    scan("R8 deselected write", 1'b0, 1'b1, 5'd0, 32'h15);
    scan("R8 deselected read", 1'b0, 1'b0, 5'd1, 32'h0);
    rd("R8 nothing changed", 5'd0);
    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      r = $urandom();
      scan("R2 R3 random", (r[7:0] != 8'd0), r[8], r[13:9], $urandom());
    end
    rd("R2 random tail", 5'd5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1 got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule